// File: doc/BRIEF.md
# Tagged Parameter Stream Demultiplexer

This block takes a stream of 32-bit tagged words from a host channel over a valid/ready handshake. It writes each value into a flat parameter register file that the surrounding logic reads in parallel. Every word names its own destination. A frame has a fixed length of seventeen words: sixteen updates for the critical parameters (IDs 0 to 15) and one update for a slow parameter whose ID the host rotates from frame to frame.

Critical updates go first into shadow storage. All sixteen become visible together when the frame closes, so a consumer never sees a mix of old and new critical values. Slow updates become visible as soon as their word is taken. When a frame closes, the block returns one acknowledgment word. This tells the host that the frame has landed in the registers and is not just sitting in a buffer. Input stays stalled until that acknowledgment has been taken.

Top module: `param_demux_top`

## Requirements
- R1: After a synchronous reset, every parameter output reads zero, `ack_valid` is 0 and `in_ready` is 1.
- R2: A word with an ID from 16 to 127 updates that parameter on the clock edge that accepts it. The parameter reads out as the word's bits [23:0] with bits [31:24] of the output forced to zero.
- R3: A word with an ID from 0 to 15 leaves the visible critical parameters unchanged until the frame closes. On the closing edge, all sixteen visible critical registers take their latest shadowed values, including a value carried by the closing word itself.
- R4: A frame closes on the 17th accepted word, counted by position regardless of ID. `ack_valid` rises on that edge.
- R5: While `ack_valid` is 1, `in_ready` is 0 and a presented input word changes no parameter and no count.
- R6: The acknowledgment word holds a frame number in bits [7:0]. It is 1 for the first frame after reset, increments per closed frame, and wraps from 255 to 0. Bits [31:9] are zero.
- R7: A word with an ID of 128 or higher writes nothing but still counts as one word of the frame. It sets the error flag reported in acknowledgment bit 8.
- R8: The error flag stays set until `err_clr` is pulsed. If a bad word and `err_clr` arrive in the same cycle, the flag ends up set.
- R9: While `ack_valid` is 1 and `ack_ready` is 0, `ack_word` holds steady. The acknowledgment is removed on the cycle after `ack_ready` is seen high.
- R10: If a frame carries the same critical ID twice, the later value is the one made visible.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| err_clr | input | 1 | Clears the sticky error flag |
| in_valid | input | 1 | Input word present |
| in_word | input | 32 | Tagged word: ID in [31:24], value in [23:0] |
| in_ready | output | 1 | Block can take a word |
| ack_valid | output | 1 | Acknowledgment word present |
| ack_word | output | 32 | Frame number [7:0], error flag [8] |
| ack_ready | input | 1 | Downstream takes the acknowledgment |
| params_out | output | 4096 | 128 parameters, 32 bits each, entry i at [32*i+31:32*i] |

## Verification
The hardest conditions to reach are the ones that depend on frame position. These are a bad or duplicated ID landing on the closing word, and the frame counter wrapping past 255. The bench reaches them by walking the rotating slot through every position of the frame. Every slow ID from 16 to 127 and every illegal ID from 128 to 255 is carried across successive frames. Enough frames are run to force the wrap. One frame holds its acknowledgment back while a word is offered, to show that the stall leaves both state and the acknowledgment untouched.

// File: rtl/pdmx_pkg.sv
package pdmx_pkg;
    localparam int WORD_W    = 32;
    localparam int ID_W      = 8;
    localparam int VAL_W     = WORD_W - ID_W;
    localparam int N_CRIT    = 16;
    localparam int N_PARAM   = 128;
    localparam int FRAME_LEN = N_CRIT + 1;
    localparam int SEQ_W     = 8;

    typedef struct packed {
        logic [ID_W-1:0]  id;
        logic [VAL_W-1:0] val;
    } tag_word_t;

    typedef enum logic [1:0] {
        K_CRIT = 2'd0,
        K_SLOW = 2'd1,
        K_BAD  = 2'd2
    } word_kind_e;

    function automatic word_kind_e classify(input logic [ID_W-1:0] id,
                                            input int n_crit, input int n_param);
        if (int'(id) < n_crit)       return K_CRIT;
        else if (int'(id) < n_param) return K_SLOW;
        else                         return K_BAD;
    endfunction

    function automatic logic [WORD_W-1:0] pack_ack(input logic [SEQ_W-1:0] seq,
                                                   input logic err);
        logic [WORD_W-1:0] w;
        w = '0;
        w[SEQ_W-1:0] = seq;
        w[SEQ_W]     = err;
        return w;
    endfunction
endpackage

// File: rtl/pd_word_decode.sv
module pd_word_decode
    import pdmx_pkg::*;
#(
    parameter int NC = N_CRIT,
    parameter int NP = N_PARAM
) (
    input  logic [WORD_W-1:0] word,
    output logic [ID_W-1:0]   id,
    output logic [VAL_W-1:0]  val,
    output logic              is_bad
);
    tag_word_t  tw;
    word_kind_e kind;

    always_comb begin
        tw     = tag_word_t'(word);
        id     = tw.id;
        val    = tw.val;
        kind   = classify(tw.id, NC, NP);
        is_bad = (kind == K_BAD);
    end
endmodule

// File: rtl/pd_frame_ctrl.sv
module pd_frame_ctrl
    import pdmx_pkg::*;
#(
    parameter int FLEN = FRAME_LEN,
    parameter int SW   = SEQ_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              is_bad,
    input  logic              err_clr,
    input  logic              ack_ready,
    output logic              in_ready,
    output logic              accept,
    output logic              commit,
    output logic              ack_valid,
    output logic [WORD_W-1:0] ack_word
);
    localparam int CW = $clog2(FLEN + 1);
    localparam logic [CW-1:0] LAST = CW'(FLEN - 1);

    logic [CW-1:0] cnt_q;
    logic [SW-1:0] seq_q;
    logic          err_q, err_d;
    logic          last;

    always_comb begin
        in_ready = ~ack_valid;
        accept   = in_valid & in_ready;
        last     = (cnt_q == LAST);
        commit   = accept & last;
        err_d    = (err_q & ~err_clr) | (accept & is_bad);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q     <= '0;
            seq_q     <= '0;
            err_q     <= 1'b0;
            ack_valid <= 1'b0;
            ack_word  <= '0;
        end else begin
            err_q <= err_d;
            if (accept)
                cnt_q <= last ? '0 : cnt_q + 1'b1;
            if (commit) begin
                seq_q     <= SW'(seq_q + 1'b1);
                ack_valid <= 1'b1;
                ack_word  <= pack_ack(SW'(seq_q + 1'b1), err_d);
            end else if (ack_valid && ack_ready) begin
                ack_valid <= 1'b0;
            end
        end
    end

    // R4: counter never leaves its frame range
    a_r4_cnt_range: assert property (@(posedge clk) disable iff (rst)
        cnt_q < CW'(FLEN));
    // R4: acknowledgment only rises after the closing word
    a_r4_ack_after_last: assert property (@(posedge clk) disable iff (rst)
        $rose(ack_valid) |-> $past(cnt_q) == LAST);
    // R5: no word counted while the acknowledgment is pending
    a_r5_stall_count: assert property (@(posedge clk) disable iff (rst)
        ack_valid |=> $stable(cnt_q));
    // R9: acknowledgment held until taken
    a_r9_ack_hold: assert property (@(posedge clk) disable iff (rst)
        ack_valid && !ack_ready |=> ack_valid && $stable(ack_word));
    // R8: error flag is sticky without a clear
    a_r8_err_sticky: assert property (@(posedge clk) disable iff (rst)
        err_q && !err_clr |=> err_q);
endmodule

// File: rtl/pd_param_regs.sv
module pd_param_regs
    import pdmx_pkg::*;
#(
    parameter int NC = N_CRIT,
    parameter int NP = N_PARAM,
    parameter int VW = VAL_W,
    parameter int IW = ID_W
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr,
    input  logic [IW-1:0]          id,
    input  logic [VW-1:0]          val,
    input  logic                   commit,
    output logic [NP-1:0][VW-1:0]  vis
);
    logic [NP-1:0]         wsel;
    logic [NC-1:0][VW-1:0] shadow_q, shadow_d;
    logic [NP-1:0][VW-1:0] vis_d;

    genvar gi;
    generate
        for (gi = 0; gi < NP; gi++) begin : g_sel
            assign wsel[gi] = wr && (int'(id) == gi);
        end
    endgenerate

    always_comb begin
        for (int i = 0; i < NC; i++)
            shadow_d[i] = wsel[i] ? val : shadow_q[i];
        for (int i = 0; i < NP; i++) begin
            if (i < NC)
                vis_d[i] = commit ? shadow_d[i] : vis[i];
            else
                vis_d[i] = wsel[i] ? val : vis[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_q <= '0;
            vis      <= '0;
        end else begin
            shadow_q <= shadow_d;
            vis      <= vis_d;
        end
    end

    // R3: visible critical set frozen between frame closes
    a_r3_crit_hold: assert property (@(posedge clk) disable iff (rst)
        !commit |=> $stable(vis[NC-1:0]));
    // R7: illegal ID writes nothing
    a_r7_bad_ignored: assert property (@(posedge clk) disable iff (rst)
        wr == 1'b0 && !commit |=> $stable(vis));
endmodule

// File: rtl/param_demux_top.sv
module param_demux_top
    import pdmx_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        err_clr,
    input  logic                        in_valid,
    input  logic [WORD_W-1:0]           in_word,
    output logic                        in_ready,
    output logic                        ack_valid,
    output logic [WORD_W-1:0]           ack_word,
    input  logic                        ack_ready,
    output logic [N_PARAM*WORD_W-1:0]   params_out
);
    logic [ID_W-1:0]                id;
    logic [VAL_W-1:0]               val;
    logic                           is_bad;
    logic                           accept, commit, wr;
    logic [N_PARAM-1:0][VAL_W-1:0]  vis;

    pd_word_decode #(.NC(N_CRIT), .NP(N_PARAM)) u_dec (
        .word(in_word), .id(id), .val(val), .is_bad(is_bad)
    );

    pd_frame_ctrl #(.FLEN(FRAME_LEN), .SW(SEQ_W)) u_ctrl (
        .clk(clk), .rst(rst), .in_valid(in_valid), .is_bad(is_bad),
        .err_clr(err_clr), .ack_ready(ack_ready), .in_ready(in_ready),
        .accept(accept), .commit(commit), .ack_valid(ack_valid),
        .ack_word(ack_word)
    );

    assign wr = accept & ~is_bad;

    pd_param_regs #(.NC(N_CRIT), .NP(N_PARAM), .VW(VAL_W), .IW(ID_W)) u_regs (
        .clk(clk), .rst(rst), .wr(wr), .id(id), .val(val),
        .commit(commit), .vis(vis)
    );

    genvar gp;
    generate
        for (gp = 0; gp < N_PARAM; gp++) begin : g_out
            assign params_out[gp*WORD_W +: WORD_W] = {{ID_W{1'b0}}, vis[gp]};
        end
    endgenerate

    // R5: input never accepted while the acknowledgment waits
    a_r5_no_accept: assert property (@(posedge clk) disable iff (rst)
        ack_valid |-> !accept);
    // R2: slow word visible the cycle after it is taken
    a_r2_slow_write: assert property (@(posedge clk) disable iff (rst)
        accept && !is_bad && int'(id) >= N_CRIT |=> vis[$past(id)] == $past(val));
endmodule

// File: tb/param_demux_top_tb.sv
module param_demux_top_tb;
    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          err_clr = 1'b0;
    logic          in_valid = 1'b0;
    logic [31:0]   in_word = '0;
    logic          in_ready;
    logic          ack_valid;
    logic [31:0]   ack_word;
    logic          ack_ready = 1'b0;
    logic [4095:0] params_out;

    param_demux_top u_dut (
        .clk(clk), .rst(rst), .err_clr(err_clr), .in_valid(in_valid),
        .in_word(in_word), .in_ready(in_ready), .ack_valid(ack_valid),
        .ack_word(ack_word), .ack_ready(ack_ready), .params_out(params_out)
    );

    always #2 clk = ~clk;

    int tests = 0;
    int fails = 0;
    logic [23:0] m_vis [128];
    logic [23:0] m_sh  [16];
    bit          m_err = 0;
    int          m_seq = 0;
    int          wcnt  = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] par(input int i);
        return params_out[i*32 +: 32];
    endfunction

    function automatic int fval(input int f, input int k);
        return (f * 7919 + k * 104729 + 3) & 32'h00FF_FFFF;
    endfunction

    task automatic send(input int id, input int v);
        in_valid = 1'b1;
        in_word  = {id[7:0], v[23:0]};
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        if (id < 16) m_sh[id] = v[23:0];
        else if (id < 128) m_vis[id] = v[23:0];
        else m_err = 1;
        wcnt++;
        if (wcnt == 17) begin
            for (int i = 0; i < 16; i++) m_vis[i] = m_sh[i];
            m_seq = (m_seq + 1) % 256;
            wcnt = 0;
        end
    endtask

    task automatic check_all(input string req);
        for (int i = 0; i < 128; i++)
            chk(par(i) == {8'h00, m_vis[i]}, req, par(i), {8'h00, m_vis[i]});
    endtask

    task automatic check_crit(input string req);
        for (int i = 0; i < 16; i++)
            chk(par(i) == {8'h00, m_vis[i]}, req, par(i), {8'h00, m_vis[i]});
    endtask

    task automatic take_ack(input string req);
        logic [31:0] exp;
        exp = {23'h0, m_err, m_seq[7:0]};
        chk(ack_valid == 1'b1, "R4 ack after 17th word", {31'h0, ack_valid}, 32'h1);
        chk(in_ready == 1'b0, "R5 stalled while ack pending", {31'h0, in_ready}, 32'h0);
        chk(ack_word == exp, req, ack_word, exp);
        ack_ready = 1'b1;
        @(negedge clk);
        ack_ready = 1'b0;
        chk(ack_valid == 1'b0 && in_ready == 1'b1, "R9 ack drops after ready",
            {30'h0, ack_valid, in_ready}, 32'h1);
    endtask

    task automatic clear_err();
        err_clr = 1'b1;
        @(negedge clk);
        err_clr = 1'b0;
        m_err = 0;
    endtask

    // one frame: 16 critical words with the rotating slot word at slot_pos
    task automatic run_frame(input int f, input int slot_id, input int slot_pos);
        int c;
        c = 0;
        for (int k = 0; k < 17; k++) begin
            if (k == slot_pos) begin
                send(slot_id, fval(f, 200 + k));
                if (slot_id >= 16 && slot_id < 128 && k < 16)
                    chk(par(slot_id) == {8'h00, m_vis[slot_id]}, "R2 slow word visible",
                        par(slot_id), {8'h00, m_vis[slot_id]});
            end else begin
                send(c, fval(f, c));
                c++;
            end
            if (k < 16) check_crit("R3 critical set unchanged mid-frame");
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin : main
        logic [31:0] held;
        for (int i = 0; i < 128; i++) m_vis[i] = '0;
        for (int i = 0; i < 16; i++) m_sh[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        check_all("R1 reset params zero");
        chk(ack_valid == 1'b0, "R1 reset ack_valid", {31'h0, ack_valid}, 32'h0);
        chk(in_ready == 1'b1, "R1 reset in_ready", {31'h0, in_ready}, 32'h1);

        // slow-ID sweep, slot walks all frame positions (R2, R3, R4, R6)
        for (int f = 0; f < 112; f++) begin
            run_frame(f, 16 + f, f % 17);
            if (f == 0) begin
                // R5 and R9: offer a word while the ack is withheld
                held = ack_word;
                in_valid = 1'b1;
                in_word  = {8'd20, 24'h5A5A5A};
                for (int j = 0; j < 3; j++) begin
                    @(negedge clk);
                    chk(ack_word == held && ack_valid, "R9 ack held stable", ack_word, held);
                    chk(par(20) == {8'h00, m_vis[20]}, "R5 stalled word ignored",
                        par(20), {8'h00, m_vis[20]});
                end
                in_valid = 1'b0;
            end
            take_ack("R6 ack frame number");
            check_all("R3 critical committed");
        end

        // illegal-ID sweep (R7)
        for (int b = 128; b < 256; b++) begin
            run_frame(b, b, b % 17);
            take_ack("R7 bad ID flags error, frame still closes");
            check_all("R7 bad ID writes nothing");
            clear_err();
        end

        // R8: sticky across a clean frame, then cleared
        run_frame(300, 255, 16);
        take_ack("R7 bad closing word");
        run_frame(301, 40, 3);
        chk(ack_word[8] == 1'b1, "R8 error stays set", {31'h0, ack_word[8]}, 32'h1);
        take_ack("R8 sticky ack");
        clear_err();
        run_frame(302, 41, 0);
        take_ack("R8 cleared error");
        // R8: clear and bad word together leaves error set
        err_clr = 1'b1;
        send(200, 1);
        err_clr = 1'b0;
        m_err = 1;
        for (int k = 0; k < 16; k++) send(k, fval(303, k));
        take_ack("R8 set wins over clear");
        clear_err();
        check_all("R7 bad first word");

        // R10: duplicate critical ID, later value wins (dup on closing word)
        for (int k = 0; k < 16; k++) send(k, fval(310, k));
        send(3, 24'hABCDEF);
        take_ack("R10 dup frame ack");
        chk(par(3) == 32'h00AB_CDEF, "R10 later duplicate wins", par(3), 32'h00AB_CDEF);
        check_all("R10 dup frame");

        // frame number wraps past 255 (R6)
        for (int f = 0; f < 20; f++) begin
            run_frame(400 + f, 60 + f, (f * 5) % 17);
            take_ack("R6 frame number wrap");
        end
        check_all("R6 final state");

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule